// File: doc/BRIEF.md
# Universal Shift Register with JK First-Stage Entry

This block is a synchronous register of parameterizable width (default 4 stages) that, on each rising clock edge, either loads all stages at once from a parallel data bus or shifts its contents one place toward the last stage. In shift mode the first stage does not take a plain serial bit. It behaves as a JK flip-flop whose K input is active low. A shift step can therefore clear, hold, toggle or set stage 0. Tying J to the active-low K input gives ordinary D-type serial entry.

An active-low asynchronous reset clears every stage at once and overrides the clock. Besides the stage values, the block drives the complement of the last stage, which is useful for serial-to-parallel, parallel-to-serial and counter-like chains.

Top module: `usr_jk`

## Requirements
- R1: When `load_ni` is 0 at a rising clock edge, `q_o` takes the value of `par_i` (bit n into stage n). `j_i` and `k_ni` have no effect.
- R2: When `load_ni` is 1 at a rising clock edge, each stage n (n >= 1) takes the previous value of stage n-1.
- R3: In shift mode with `j_i`=0 and `k_ni`=0, stage 0 becomes 0.
- R4: In shift mode with `j_i`=0 and `k_ni`=1, stage 0 keeps its value.
- R5: In shift mode with `j_i`=1 and `k_ni`=0, stage 0 becomes the complement of its previous value.
- R6: In shift mode with `j_i`=1 and `k_ni`=1, stage 0 becomes 1.
- R7: While `rst_ni` is 0, all stages are 0. This takes effect without waiting for a clock edge and holds through any clock edge that occurs during reset.
- R8: `q_last_no` is always the complement of stage WIDTH-1. It is therefore 1 during reset.
- R9: In shift mode `par_i` has no effect on any stage.
- R10: The first rising edge after `rst_ni` returns to 1 performs a normal load or shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | 0 = parallel load, 1 = shift |
| par_i | input | WIDTH | Parallel data, bit n feeds stage n |
| j_i | input | 1 | J input of first stage |
| k_ni | input | 1 | Active-low K input of first stage |
| q_o | output | WIDTH | Stage values, bit n is stage n |
| q_last_no | output | 1 | Complement of the last stage |

## Verification
The clocked properties assume that `load_ni`, `j_i`, `k_ni` and `par_i` are stable around each rising edge, and they are disabled while `rst_ni` is low. The bench changes every input only on the falling clock edge. It asserts and releases reset only away from the rising edge, so that no recovery-time race exists. Reset pulses are dropped at random points in the sequence and are deliberately held across a rising edge with load data present, which exercises the override.

// File: rtl/usr_jk_pkg.sv
package usr_jk_pkg;

  // first-stage operation selected by {j, k_n}
  typedef enum logic [1:0] {
    JK_CLEAR  = 2'b00,
    JK_HOLD   = 2'b01,
    JK_TOGGLE = 2'b10,
    JK_SET    = 2'b11
  } jk_op_e;

  function automatic logic jk_next(input logic j, input logic k_n, input logic cur);
    jk_op_e op;
    op = jk_op_e'({j, k_n});
    case (op)
      JK_CLEAR:  return 1'b0;
      JK_HOLD:   return cur;
      JK_TOGGLE: return ~cur;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/usr_jk_head.sv
module usr_jk_head (
  input  logic cur_i,
  input  logic j_i,
  input  logic k_ni,
  output logic next_o
);
  import usr_jk_pkg::*;

  always_comb next_o = jk_next(j_i, k_ni, cur_i);

endmodule

// File: rtl/usr_jk_stage.sv
module usr_jk_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_ni,
  input  logic par_i,
  input  logic ser_i,
  output logic q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (!load_ni) q_o <= par_i;
    else              q_o <= ser_i;
  end

  p_stage_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_o == $past(par_i));

  p_stage_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |=> q_o == $past(ser_i));

endmodule

// File: rtl/usr_jk.sv
module usr_jk #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             j_i,
  input  logic             k_ni,
  output logic [WIDTH-1:0] q_o,
  output logic             q_last_no
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] ser;
  logic             head_next;

  usr_jk_head u_head (
    .cur_i  (q_o[0]),
    .j_i    (j_i),
    .k_ni   (k_ni),
    .next_o (head_next)
  );

  assign ser[0] = head_next;

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    if (g > 0) begin : g_link
      assign ser[g] = q_o[g-1];
    end
    usr_jk_stage u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_ni (load_ni),
      .par_i   (par_i[g]),
      .ser_i   (ser[g]),
      .q_o     (q_o[g])
    );
  end

  assign q_last_no = ~q_o[LAST];

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |=> q_o[LAST:1] == $past(q_o[LAST-1:0]));

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_o == $past(par_i));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !j_i && !k_ni) |=> !q_o[0]);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !j_i && k_ni) |=> $stable(q_o[0]));

  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && j_i && !k_ni) |=> q_o[0] != $past(q_o[0]));

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && j_i && k_ni) |=> q_o[0]);

endmodule

// File: tb/usr_jk_bench.sv
module usr_jk_bench;
  localparam int W = 4;
  localparam time PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_ni = 1'b0;
  logic [W-1:0] par = '0;
  logic         j = 1'b0;
  logic         k_n = 1'b0;
  logic [W-1:0] q;
  logic         q_last_n;

  int n_cmp = 0;
  int n_bad = 0;
  int model [W];
  string tag = "R7";

  usr_jk #(.WIDTH(W)) u_usr_jk (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(load_ni), .par_i(par),
    .j_i(j), .k_ni(k_n), .q_o(q), .q_last_no(q_last_n)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < W; i++) model[i] = 0;
    end else if (!load_ni) begin
      for (int i = 0; i < W; i++) model[i] = int'(par[i]);
    end else begin
      for (int i = W-1; i > 0; i--) model[i] = model[i-1];
      if (!j && !k_n)      model[0] = 0;
      else if (!j && k_n)  model[0] = model[0];
      else if (j && !k_n)  model[0] = 1 - model[0];
      else                 model[0] = 1;
    end
  end

  function automatic logic [W-1:0] model_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = model[i][0];
    return v;
  endfunction

  task automatic compare(input string t);
    logic [W-1:0] exp_v;
    exp_v = model_vec();
    n_cmp++;
    if (q !== exp_v) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", t, q, exp_v);
    end
    n_cmp++;
    if (q_last_n !== ~exp_v[W-1]) begin
      n_bad++;
      $display("FAIL R8 (%s): q_last_n=%b expected %b", t, q_last_n, ~exp_v[W-1]);
    end
  endtask

  task automatic set_inputs(input logic ld_n, input logic [W-1:0] p,
                            input logic jj, input logic kk);
    load_ni = ld_n; par = p; j = jj; k_n = kk;
    if (!ld_n) tag = "R1 R9";
    else if (!jj && !kk) tag = "R2 R3 R9";
    else if (!jj && kk)  tag = "R2 R4 R9";
    else if (jj && !kk)  tag = "R2 R5 R9";
    else                 tag = "R2 R6 R9";
  endtask

  // called just after a falling edge
  task automatic pulse_reset();
    #(PERIOD/4);
    rst_ni = 1'b0;
    #1;
    compare("R7 immediate");
    set_inputs(1'b0, '1, 1'b1, 1'b1);
    @(negedge clk);
    compare("R7 override");
    rst_ni = 1'b1;
    tag = "R10";
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    set_inputs(1'b0, 4'b1111, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    compare("R7 reset state");
    rst_ni = 1'b1;
    // R10: first edge after release loads
    set_inputs(1'b0, 4'b1010, 1'b1, 1'b1);
    tag = "R10 R1";
    @(negedge clk); compare(tag);
    // directed sweep of each first-stage op with par pattern that must be ignored
    set_inputs(1'b1, 4'b1111, 1'b1, 1'b0); @(negedge clk); compare(tag);
    set_inputs(1'b1, 4'b0000, 1'b1, 1'b0); @(negedge clk); compare(tag);
    set_inputs(1'b1, 4'b1111, 1'b0, 1'b1); @(negedge clk); compare(tag);
    set_inputs(1'b1, 4'b1111, 1'b0, 1'b0); @(negedge clk); compare(tag);
    set_inputs(1'b1, 4'b0000, 1'b1, 1'b1); @(negedge clk); compare(tag);
    set_inputs(1'b0, 4'b0110, 1'b0, 1'b0); @(negedge clk); compare(tag);
    pulse_reset();
    set_inputs(1'b1, 4'b0000, 1'b1, 1'b1);
    tag = "R10 R6";
    @(negedge clk); compare(tag);
    // random sequence
    for (int c = 0; c < 2000; c++) begin
      if ($urandom_range(0, 49) == 0) begin
        pulse_reset();
        set_inputs(logic'($urandom_range(0, 1)), W'($urandom),
                   logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
        tag = {"R10 ", tag};
      end else begin
        set_inputs(logic'($urandom_range(0, 3) != 0), W'($urandom),
                   logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
      end
      @(negedge clk);
      compare(tag);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule